// File: doc/BRIEF.md
# Decimating Acquisition Save Controller

This block decides when digitized samples are written into the acquisition memory after the pre-trigger samples that are not needed have been discarded. A base write tick (nominally 2 MHz) arrives as a one-cycle enable. The block owns the memory from a start pulse until the record is full. While it owns the memory, it either passes every tick as a write or thins the ticks into short bursts separated by suppressed gaps.

In the two thinned modes, each burst stores one point per channel, or a maximum and a minimum per channel in envelope mode. The burst is followed by a gap of N base ticks, where N is the time-per-division setting divided by 50 µs. This keeps the stored density at a fixed number of samples per division. Each write steps a wrapping address counter, and a record-end register captures the address that was written. After the last write of the record, the block releases the memory to the processor and pulses a completion strobe.

Top module: `acq_save_ctrl`

## Requirements
- R1: After reset, `mem_we`, `done_pulse` and `own_mem` are 0, and `wr_addr` and `rec_end` are 0.
- R2: While `own_mem` is 0, no tick produces a write. A `start` pulse seen while `own_mem` is 0 sets `own_mem` to 1 from the next cycle.
- R3: In mode 0 (full rate), and in reserved mode 3 which behaves the same, every `base_tick` cycle while `own_mem` is 1 asserts `mem_we` in that same cycle.
- R4: In mode 1 (decimated), the first two ticks after start are writes. After each burst of two writes, the next N ticks produce no write, and then the next burst begins.
- R5: In mode 2 (envelope), each burst is four writes long (min and max for two channels). It is followed by N suppressed ticks.
- R6: N is taken from `div_n` in the cycle `start` is accepted. Later changes to `div_n` have no effect on the running record. A `div_n` of 0 acts as 1.
- R7: Each write advances `wr_addr` by 1 modulo 2048, and the address is otherwise held. The address is not cleared by `start`, so the next record continues from where the last one ended.
- R8: After each write, `rec_end` holds the address at which that write was made.
- R9: The 2048th write of a record (1024 per channel) is its last one. In the next cycle `own_mem` is 0 and `done_pulse` is 1 for exactly one cycle, and no further writes occur.
- R10: A `start` pulse while `own_mem` is 1 is ignored. The record still ends after exactly 2048 writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_tick | input | 1 | One-cycle base write tick enable |
| start | input | 1 | Pre-trigger discard finished; begin saving |
| mode | input | 2 | 0 full, 1 decimated, 2 envelope, 3 as full |
| div_n | input | 8 | Gap length in ticks (time-per-division / 50 µs) |
| mem_we | output | 1 | Memory write enable, valid in the tick cycle |
| wr_addr | output | 11 | Address of the current or next write |
| rec_end | output | 11 | Address of the most recent write |
| own_mem | output | 1 | High while this block owns the memory |
| done_pulse | output | 1 | One-cycle record-complete strobe |

## Verification
Full-rate mode is run with a tick every cycle. This checks that no tick is swallowed and that the end of the record falls on exactly the 2048th write. A start pulse is injected mid-run to show that it is ignored. Decimated mode with N=4 and a tick every cycle separates the two-write burst from the gap. The N=4 run also changes `div_n` mid-run, which would expose a divisor that is re-read after start. Envelope mode with N=2 and a tick every other cycle checks that the gap counts ticks and not clock cycles, and that the burst length is four. A run with `div_n` of 0 checks the clamp to a one-tick gap. The scoreboard compares every cycle's write enable, address, record end, ownership and strobe against a model built from the requirements.

// File: rtl/acq_save_pkg.sv
// Package: shared types for the acquisition save controller.
// Assumes: mode code 3 is reserved and is treated like full rate.
package acq_save_pkg;

    typedef enum logic [1:0] {
        SAVE_FULL  = 2'd0,
        SAVE_DECIM = 2'd1,
        SAVE_ENV   = 2'd2,
        SAVE_RSVD  = 2'd3
    } save_mode_e;

    // True when the mode thins ticks into bursts and gaps.
    function automatic logic mode_thins(input save_mode_e m);
        return (m == SAVE_DECIM) || (m == SAVE_ENV);
    endfunction

endpackage

// File: rtl/acq_tick_gate.sv
// Module: acq_tick_gate
// Decides which base ticks become memory writes. In the thinning modes it
// lets a burst of writes through and then swallows a gap of n ticks.
// Assumes: gap_n >= 1 and it is stable while run is high; arm is only
// asserted while run is low.
module acq_tick_gate
    import acq_save_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DIV_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             arm,
    input  logic             tick,
    input  save_mode_e       mode_q,
    input  logic [DIV_W-1:0] gap_n,
    output logic             pass
);

    localparam int BURST_PLAIN = NUM_CH;
    localparam int BURST_ENV   = 2 * NUM_CH;
    localparam int BW          = $clog2(BURST_ENV + 1);

    logic          in_gap;
    logic [BW-1:0] burst_cnt;
    logic [DIV_W-1:0] gap_cnt;
    logic [BW-1:0] burst_last;
    logic          thin;

    // Purpose: choose the last index of a burst for the latched mode.
    always_comb begin
        thin       = mode_thins(mode_q);
        burst_last = (mode_q == SAVE_ENV) ? BW'(BURST_ENV - 1) : BW'(BURST_PLAIN - 1);
    end

    // Purpose: a tick becomes a write unless a thinning gap is open.
    assign pass = run && tick && (!thin || !in_gap);

    // Purpose: step the burst and gap counters on each tick while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_gap    <= 1'b0;
            burst_cnt <= '0;
            gap_cnt   <= '0;
        end else if (arm) begin
            in_gap    <= 1'b0;
            burst_cnt <= '0;
            gap_cnt   <= '0;
        end else if (run && tick && thin) begin
            if (!in_gap) begin
                if (burst_cnt == burst_last) begin
                    in_gap    <= 1'b1;
                    gap_cnt   <= gap_n;
                    burst_cnt <= '0;
                end else begin
                    burst_cnt <= burst_cnt + 1'b1;
                end
            end else if (gap_cnt == DIV_W'(1)) begin
                in_gap <= 1'b0;
            end else begin
                gap_cnt <= gap_cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/acq_addr_track.sv
// Module: acq_addr_track
// Holds the wrapping acquisition address and the record-end latch.
// Assumes: wr is high for exactly the cycles in which memory is written.
module acq_addr_track #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    output logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] last_addr
);

    // Purpose: advance the address and capture the written one on each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr      <= '0;
            last_addr <= '0;
        end else if (wr) begin
            addr      <= addr + 1'b1;
            last_addr <= addr;
        end
    end

endmodule

// File: rtl/acq_fill_count.sv
// Module: acq_fill_count
// Counts writes in the current record and flags the final one.
// Assumes: clr and wr are never high together.
module acq_fill_count #(
    parameter int TOTAL = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic wr,
    output logic last_wr
);

    localparam int CW = $clog2(TOTAL);

    logic [CW-1:0] cnt;

    // Purpose: the write that brings the count to TOTAL is the last one.
    assign last_wr = wr && (cnt == CW'(TOTAL - 1));

    // Purpose: keep the count of stored samples for this record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (wr) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/acq_save_ctrl.sv
// Module: acq_save_ctrl (top)
// Takes memory ownership on start, gates base ticks into writes by mode,
// tracks the address and record end, and releases memory with a one-cycle
// strobe once the record is full.
// Assumes: base_tick is a one-cycle enable and start is a one-cycle pulse.
module acq_save_ctrl
    import acq_save_pkg::*;
#(
    parameter int NUM_CH  = 2,
    parameter int REC_LEN = 1024,
    parameter int ADDR_W  = 11,
    parameter int DIV_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_tick,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [DIV_W-1:0]  div_n,
    output logic              mem_we,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rec_end,
    output logic              own_mem,
    output logic              done_pulse
);

    localparam int TOTAL = NUM_CH * REC_LEN;

    save_mode_e       mode_q;
    logic [DIV_W-1:0] gap_q;
    logic             accept;
    logic             pass;
    logic             last_wr;

    // Purpose: a start counts only while the memory is not owned.
    assign accept = start && !own_mem;

    // Purpose: latch mode and clamped divisor when a record begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= SAVE_FULL;
            gap_q  <= DIV_W'(1);
        end else if (accept) begin
            mode_q <= save_mode_e'(mode);
            gap_q  <= (div_n == '0) ? DIV_W'(1) : div_n;
        end
    end

    // Purpose: ownership and completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_mem    <= 1'b0;
            done_pulse <= 1'b0;
        end else begin
            done_pulse <= last_wr;
            if (accept) begin
                own_mem <= 1'b1;
            end else if (last_wr) begin
                own_mem <= 1'b0;
            end
        end
    end

    acq_tick_gate #(
        .NUM_CH (NUM_CH),
        .DIV_W  (DIV_W)
    ) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (own_mem),
        .arm    (accept),
        .tick   (base_tick),
        .mode_q (mode_q),
        .gap_n  (gap_q),
        .pass   (pass)
    );

    acq_addr_track #(
        .ADDR_W (ADDR_W)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (pass),
        .addr      (wr_addr),
        .last_addr (rec_end)
    );

    acq_fill_count #(
        .TOTAL (TOTAL)
    ) u_fill (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept),
        .wr      (pass),
        .last_wr (last_wr)
    );

    assign mem_we = pass;

endmodule

// File: rtl/acq_save_ctrl_chk.sv
// Module: acq_save_ctrl_chk
// Port-level temporal checks for acq_save_ctrl, attached by bind.
module acq_save_ctrl_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              base_tick,
    input logic              mem_we,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [ADDR_W-1:0] rec_end,
    input logic              own_mem,
    input logic              done_pulse
);

    p_idle_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !own_mem |-> !mem_we);

    p_write_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> base_tick);

    p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> wr_addr == $past(wr_addr) + 1'b1);

    p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we |=> $stable(wr_addr));

    p_rec_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> rec_end == $past(wr_addr));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    p_done_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> !own_mem);

    p_release_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(own_mem) |-> done_pulse);

endmodule

bind acq_save_ctrl acq_save_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .base_tick  (base_tick),
    .mem_we     (mem_we),
    .wr_addr    (wr_addr),
    .rec_end    (rec_end),
    .own_mem    (own_mem),
    .done_pulse (done_pulse)
);

// File: tb/acq_save_ctrl_bench.sv
module acq_save_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_tick = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [7:0]  div_n = 8'd1;
    logic        mem_we;
    logic [10:0] wr_addr;
    logic [10:0] rec_end;
    logic        own_mem;
    logic        done_pulse;

    int vectors = 0;
    int errors  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    acq_save_ctrl u_acq_save_ctrl (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .start(start),
        .mode(mode), .div_n(div_n), .mem_we(mem_we), .wr_addr(wr_addr),
        .rec_end(rec_end), .own_mem(own_mem), .done_pulse(done_pulse)
    );

    typedef struct {
        logic        we;
        logic [10:0] addr;
        logic [10:0] rec;
        logic        owns;
        logic        done;
        string       tag;
    } exp_t;

    exp_t sbq[$];

    // Reference model state, derived from the requirements.
    logic        e_owns = 0, e_done = 0, e_gap = 0;
    logic [10:0] e_addr = 0, e_rec = 0;
    int          e_cnt = 0, e_b = 0, e_g = 0, e_n = 1;
    logic [1:0]  e_mode = 0;
    string       cur_tag = "R2";
    int          done_seen = 0, wr_seen = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus plus the expected item for that cycle.
    task automatic step(input logic tk, input logic st);
        exp_t it;
        logic we_e, own0, thin;
        int bl;
        @(posedge clk); #1;
        base_tick = tk;
        start = st;
        thin = (e_mode == 2'd1) || (e_mode == 2'd2);
        bl = (e_mode == 2'd2) ? 4 : 2;
        we_e = e_owns && tk && (!thin || !e_gap);
        it.we = we_e; it.addr = e_addr; it.rec = e_rec;
        it.owns = e_owns; it.done = e_done; it.tag = cur_tag;
        sbq.push_back(it);
        own0 = e_owns;
        e_done = 0;
        if (we_e) begin
            e_rec = e_addr;
            e_addr = e_addr + 11'd1;
            e_cnt++;
            if (e_cnt == 2048) begin
                e_owns = 0;
                e_done = 1;
            end
        end
        if (own0 && tk && thin) begin
            if (!e_gap) begin
                if (e_b == bl - 1) begin e_gap = 1; e_g = e_n; e_b = 0; end
                else e_b++;
            end else if (e_g == 1) e_gap = 0;
            else e_g--;
        end
        if (st && !own0) begin
            e_owns = 1; e_cnt = 0; e_gap = 0; e_b = 0;
            e_mode = mode;
            e_n = (div_n == 0) ? 1 : int'(div_n);
        end
    endtask

    // Monitor: pop and compare at the falling edge.
    always @(negedge clk) begin
        if (rst_n && sbq.size() > 0) begin
            exp_t it;
            it = sbq.pop_front();
            check(it.tag, "mem_we", int'(mem_we), int'(it.we));
            check("R7", "wr_addr", int'(wr_addr), int'(it.addr));
            check("R8", "rec_end", int'(rec_end), int'(it.rec));
            check("R9", "own_mem", int'(own_mem), int'(it.owns));
            check("R9", "done_pulse", int'(done_pulse), int'(it.done));
            if (done_pulse) done_seen++;
            if (mem_we) wr_seen++;
        end
    end

    task automatic run_acq(input logic [1:0] m, input logic [7:0] n, input int period,
                           input bit poke, input string tag);
        int k;
        logic [10:0] a0;
        a0 = e_addr;
        mode = m;
        div_n = n;
        cur_tag = tag;
        done_seen = 0;
        wr_seen = 0;
        step(1'b0, 1'b1);
        k = 0;
        while (e_owns) begin
            step((k % period) == 0, poke && (k == 10));
            if (k == 20) div_n = 8'd1;  // R6: change after start must not matter
            k++;
        end
        repeat (3) step(1'b1, 1'b0);
        @(negedge clk); #1;
        check("R9", "done pulses per record", done_seen, 1);
        check(poke ? "R10" : "R9", "writes per record", wr_seen, 2048);
        check("R7", "address after full record", int'(wr_addr), int'(a0));
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            errors++;
            vectors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "mem_we", int'(mem_we), 0);
        check("R1", "done_pulse", int'(done_pulse), 0);
        check("R1", "own_mem", int'(own_mem), 0);
        check("R1", "wr_addr", int'(wr_addr), 0);
        check("R1", "rec_end", int'(rec_end), 0);
        // R2: ticks while idle do not write
        cur_tag = "R2";
        repeat (5) step(1'b1, 1'b0);
        // R3 full rate, with an ignored mid-run start (R10)
        run_acq(2'd0, 8'd3, 1, 1'b1, "R3");
        // R4 decimated, N=4, divisor changed mid-run (R6)
        run_acq(2'd1, 8'd4, 1, 1'b0, "R4");
        // R5 envelope, N=2, tick every other cycle
        run_acq(2'd2, 8'd2, 2, 1'b0, "R5");
        // R6 divisor 0 acts as 1
        run_acq(2'd1, 8'd0, 1, 1'b0, "R6");
        // R3 reserved mode behaves as full rate
        run_acq(2'd3, 8'd5, 3, 1'b0, "R3");
        repeat (2) step(1'b0, 1'b0);
        @(negedge clk); #1;
        check("R8", "final rec_end", int'(rec_end), int'(e_rec));
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule